// File: doc/BRIEF.md
# Nanosecond Real-Time Counter with One-Shot Alarm

This block is a register-mapped real-time counter that holds a 64-bit time value in nanoseconds. On every clock the value grows by a fixed step that a parameter sets, so the counter tracks elapsed time at the clock rate. Software reaches the block through a 32-bit register port that has a valid strobe, a write flag, a byte address and write data. Read data is registered and appears on the cycle after the access.

Each 64-bit quantity is split into two 32-bit words. Time reads cannot tear, because reading the lower word captures the upper word into a shadow at the same moment. Writes cannot tear either: the upper word is staged first, and the lower-word write commits both halves at once. A one-shot alarm compares the counter against a 64-bit threshold. When the alarm fires it sets a pending flag, and that flag drives a level interrupt through an enable bit. Two write-to-clear controls let software disarm the alarm or drop the pending interrupt.

Top module: `ns_rtc`

## Requirements
- R1: After synchronous reset the counter, the committed alarm, the armed flag, the pending flag and the interrupt enable are all zero, and `irq` is low.
- R2: The counter increases by NS_PER_TICK (default 10) on every clock edge that has no time load, and it wraps modulo 2^64.
- R3: A read of word 0x00 returns bits 31:0 of the live counter and copies bits 63:32 into a shadow. A read of word 0x04 returns that shadow, not the live upper word.
- R4: A write to 0x04 only stages an upper time word and leaves the counter unchanged. A write to 0x00 loads the counter with {staged upper, written data}.
- R5: A write to 0x0C only stages an upper alarm word. A write to 0x08 commits {staged alarm upper, written data} as the alarm and arms it. Reads of 0x08 and 0x0C return the committed alarm, and a read of 0x18 returns 1 while the alarm is armed and 0 otherwise.
- R6: On an edge where the alarm is armed and the counter is greater than or equal to the alarm, the pending flag is set and the armed flag is cleared. The alarm fires once per arming.
- R7: A write to 0x14 with bit 0 set disarms the alarm and does not set the pending flag. With bit 0 clear the write has no effect.
- R8: A write to 0x1C with bit 0 set clears the pending flag. With bit 0 clear the write has no effect.
- R9: Bit 0 of a write to 0x10 sets the interrupt enable, which reads back at 0x10. `irq` equals pending AND enable, updated on the same edge as both of them.
- R10: Reads of 0x14 and 0x1C return zero. `rdata` changes only on a read access and is valid on the cycle after it.
- R11: The upper time staging word and the upper alarm staging word are separate registers, so staging one never alters the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 4:2 select the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, pending AND enable |

## Verification
The assertions assume that each cycle carries at most one access, so a single edge never sees two register actions such as clearing the alarm and clearing the interrupt together. They also assume that reset is held for at least one edge before any access. The stimulus drives one access per cycle through a single task, changes inputs only on the falling edge, and releases reset only after several reset edges. When a check depends on the exact time an alarm fires, the alarm is set a known number of steps ahead of a freshly loaded counter. Alarm values placed far in the future or in the past are used to test one-shot firing and disarming.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    SEL_TIME_LO  = 3'd0,
    SEL_TIME_HI  = 3'd1,
    SEL_ALARM_LO = 3'd2,
    SEL_ALARM_HI = 3'd3,
    SEL_IRQ_EN   = 3'd4,
    SEL_DISARM   = 3'd5,
    SEL_STATUS   = 3'd6,
    SEL_ACK_IRQ  = 3'd7
  } reg_sel_t;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 64,
  parameter int STEP  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else           cnt <= cnt + STEP_V;
  end

  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> cnt == $past(cnt) + STEP_V);
  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(load_val));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             arm_we,
  input  logic [CNT_W-1:0] arm_val,
  input  logic             disarm,
  input  logic             ack,
  output logic [CNT_W-1:0] alarm_q,
  output logic             armed_q,
  output logic             pend_q,
  output logic             pend_nxt
);
  logic hit, fire, armed_nxt;

  assign hit  = cnt >= alarm_q;
  assign fire = armed_q & hit;

  always_comb begin
    armed_nxt = armed_q;
    if (arm_we)              armed_nxt = 1'b1;
    else if (fire || disarm) armed_nxt = 1'b0;
    pend_nxt = pend_q;
    if (fire)     pend_nxt = 1'b1;
    else if (ack) pend_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (arm_we) alarm_q <= arm_val;
      armed_q <= armed_nxt;
      pend_q  <= pend_nxt;
    end
  end

  assert_fire_once_R6: assert property (@(posedge clk) disable iff (rst)
    (armed_q && cnt >= alarm_q && !arm_we) |=> (!armed_q && pend_q));
  assert_disarm_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (disarm && !arm_we && !(armed_q && cnt >= alarm_q)) |=> (!armed_q && $stable(pend_q)));
  assert_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && !(armed_q && cnt >= alarm_q)) |=> !pend_q);
  assert_arm_R5: assert property (@(posedge clk) disable iff (rst)
    arm_we |=> (armed_q && alarm_q == $past(arm_val)));
endmodule

// File: rtl/ns_rtc.sv
module ns_rtc #(
  parameter int NS_PER_TICK = 10,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import rtc_pkg::*;
  localparam int CNT_W = 2 * DATA_W;

  reg_sel_t          sel;
  logic              wr, rd;
  logic [CNT_W-1:0]  cnt, alarm_q;
  logic              armed_q, pend_q, pend_nxt;
  logic [DATA_W-1:0] time_stage, alarm_stage, shadow;
  logic              en_q, en_nxt;
  logic [DATA_W-1:0] rd_mux;

  assign sel = reg_sel_t'(bus_addr[4:2]);
  assign wr  = bus_valid & bus_write;
  assign rd  = bus_valid & ~bus_write;

  rtc_counter #(.CNT_W(CNT_W), .STEP(NS_PER_TICK)) u_cnt (
    .clk(clk), .rst(rst),
    .load(wr && sel == SEL_TIME_LO),
    .load_val({time_stage, bus_wdata}),
    .cnt(cnt)
  );

  rtc_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk(clk), .rst(rst), .cnt(cnt),
    .arm_we(wr && sel == SEL_ALARM_LO),
    .arm_val({alarm_stage, bus_wdata}),
    .disarm(wr && sel == SEL_DISARM && bus_wdata[0]),
    .ack(wr && sel == SEL_ACK_IRQ && bus_wdata[0]),
    .alarm_q(alarm_q), .armed_q(armed_q),
    .pend_q(pend_q), .pend_nxt(pend_nxt)
  );

  assign en_nxt = (wr && sel == SEL_IRQ_EN) ? bus_wdata[0] : en_q;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_TIME_LO:  rd_mux = cnt[DATA_W-1:0];
      SEL_TIME_HI:  rd_mux = shadow;
      SEL_ALARM_LO: rd_mux = alarm_q[DATA_W-1:0];
      SEL_ALARM_HI: rd_mux = alarm_q[CNT_W-1:DATA_W];
      SEL_IRQ_EN:   rd_mux = DATA_W'(en_q);
      SEL_STATUS:   rd_mux = DATA_W'(armed_q);
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_stage  <= '0;
      alarm_stage <= '0;
      shadow      <= '0;
      en_q        <= 1'b0;
      irq         <= 1'b0;
      bus_rdata   <= '0;
    end else begin
      if (wr && sel == SEL_TIME_HI)  time_stage  <= bus_wdata;
      if (wr && sel == SEL_ALARM_HI) alarm_stage <= bus_wdata;
      if (rd && sel == SEL_TIME_LO)  shadow      <= cnt[CNT_W-1:DATA_W];
      if (rd)                        bus_rdata   <= rd_mux;
      en_q <= en_nxt;
      irq  <= pend_nxt & en_nxt;
    end
  end

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (pend_q && en_q));
  assert_shadow_R3: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_TIME_LO) |=> shadow == $past(cnt[CNT_W-1:DATA_W]));
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata));
  assert_stage_split_R11: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_TIME_HI) |=> $stable(alarm_stage));
endmodule

// File: tb/sim_ns_rtc.sv
module sim_ns_rtc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ns_rtc u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] data;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'h04, 32'h3,        1'b0, 32'h0,        4'd4},  // R4 stage
    '{1'b1, 5'h00, 32'h100,      1'b0, 32'h0,        4'd4},  // R4 commit
    '{1'b0, 5'h00, 32'h0,        1'b1, 32'h100,      4'd4},  // R4 loaded value
    '{1'b0, 5'h00, 32'h0,        1'b1, 32'h10A,      4'd2},  // R2 one step
    '{1'b0, 5'h04, 32'h0,        1'b1, 32'h3,        4'd3},  // R3 shadow
    '{1'b1, 5'h0C, 32'h5,        1'b0, 32'h0,        4'd5},  // R5 stage only
    '{1'b0, 5'h0C, 32'h0,        1'b1, 32'h0,        4'd5},  // R5 not committed
    '{1'b0, 5'h18, 32'h0,        1'b1, 32'h0,        4'd5},  // R5 not armed
    '{1'b1, 5'h04, 32'h3,        1'b0, 32'h0,        4'd11}, // R11 interleave
    '{1'b1, 5'h08, 32'hFFFF0000, 1'b0, 32'h0,        4'd5},  // R5 arm
    '{1'b0, 5'h18, 32'h0,        1'b1, 32'h1,        4'd5},  // R5 armed
    '{1'b0, 5'h0C, 32'h0,        1'b1, 32'h5,        4'd11}, // R11 own stage
    '{1'b0, 5'h08, 32'h0,        1'b1, 32'hFFFF0000, 4'd5},
    '{1'b1, 5'h00, 32'h20,       1'b0, 32'h0,        4'd4},
    '{1'b0, 5'h00, 32'h0,        1'b1, 32'h20,       4'd4},
    '{1'b0, 5'h04, 32'h0,        1'b1, 32'h3,        4'd11}, // R11
    '{1'b0, 5'h14, 32'h0,        1'b1, 32'h0,        4'd10}, // R10
    '{1'b0, 5'h1C, 32'h0,        1'b1, 32'h0,        4'd10}, // R10
    '{1'b1, 5'h14, 32'h0,        1'b0, 32'h0,        4'd7},  // R7 bit0 clear
    '{1'b0, 5'h18, 32'h0,        1'b1, 32'h1,        4'd7},
    '{1'b1, 5'h14, 32'h1,        1'b0, 32'h0,        4'd7},  // R7 disarm
    '{1'b0, 5'h18, 32'h0,        1'b1, 32'h0,        4'd7}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [4:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    acc(0, 5'h00, 0); check("R1 counter", bus_rdata, 32'h0);
    acc(0, 5'h08, 0); check("R1 alarm lo", bus_rdata, 32'h0);
    acc(0, 5'h0C, 0); check("R1 alarm hi", bus_rdata, 32'h0);
    acc(0, 5'h10, 0); check("R1 enable", bus_rdata, 32'h0);
    acc(0, 5'h18, 0); check("R1 armed", bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].wr, VEC[i].addr, VEC[i].data);
      if (VEC[i].chk) check($sformatf("R%0d vec%0d", VEC[i].req, i), bus_rdata, VEC[i].exp);
    end

    // R7: the disarm raised nothing
    acc(1, 5'h10, 1);
    check("R7 no irq after disarm", {31'b0, irq}, 32'h0);
    acc(0, 5'h10, 0); check("R9 enable readback", bus_rdata, 32'h1);

    // R6 / R9 timed fire: counter 1000, alarm 1050
    acc(1, 5'h04, 0);
    acc(1, 5'h00, 1000);
    acc(1, 5'h0C, 0);
    acc(1, 5'h08, 1050);
    check("R6 not early", {31'b0, irq}, 32'h0);
    idle(2);
    check("R6 not early 2", {31'b0, irq}, 32'h0);
    idle(5);
    check("R6 fired", {31'b0, irq}, 32'h1);
    acc(0, 5'h18, 0); check("R6 disarmed", bus_rdata, 32'h0);
    acc(1, 5'h10, 0); check("R9 gate off", {31'b0, irq}, 32'h0);
    acc(1, 5'h10, 1); check("R9 gate on", {31'b0, irq}, 32'h1);
    acc(1, 5'h1C, 0); check("R8 bit0 clear ignored", {31'b0, irq}, 32'h1);
    acc(1, 5'h1C, 1); check("R8 ack", {31'b0, irq}, 32'h0);
    idle(20);
    check("R6 one shot", {31'b0, irq}, 32'h0);

    // R6 alarm already in the past
    acc(1, 5'h0C, 0);
    acc(1, 5'h08, 0);
    idle(2);
    check("R6 past alarm", {31'b0, irq}, 32'h1);
    acc(0, 5'h18, 0); check("R6 past disarmed", bus_rdata, 32'h0);
    acc(1, 5'h1C, 1);

    // R7 disarm before a far alarm
    acc(1, 5'h08, 5000);
    acc(1, 5'h14, 1);
    idle(400);
    check("R7 disarmed never fires", {31'b0, irq}, 32'h0);
    acc(0, 5'h18, 0); check("R7 status", bus_rdata, 32'h0);

    // R2 wrap modulo 2^64
    acc(1, 5'h04, 32'hFFFFFFFF);
    acc(1, 5'h00, 32'hFFFFFFF6);
    acc(0, 5'h00, 0); check("R2 before wrap", bus_rdata, 32'hFFFFFFF6);
    acc(0, 5'h00, 0); check("R2 wrapped lo", bus_rdata, 32'h0);
    acc(0, 5'h04, 0); check("R2 wrapped hi", bus_rdata, 32'h0);

    // R3 tear-free upper word
    acc(1, 5'h04, 32'h1);
    acc(1, 5'h00, 32'hFFFFFFE2);
    acc(0, 5'h00, 0); check("R3 live lo", bus_rdata, 32'hFFFFFFE2);
    idle(5);
    acc(0, 5'h04, 0); check("R3 shadow held", bus_rdata, 32'h1);
    acc(0, 5'h00, 0);
    acc(0, 5'h04, 0); check("R3 shadow updated", bus_rdata, 32'h2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule